// File: doc/BRIEF.md
# Linked-List Block Queue Manager

This block keeps several output queues in a large external memory, each as a chain of fixed-size blocks. The head and tail block number of every queue live in on-chip registers. Each block holds `BLK_WORDS` data words followed by one link word that names the next block in the chain, so the chain pointers sit in the external memory beside the data. Spare blocks are kept on a free chain that is threaded through the same link words.

A command carries an operation code and a queue number. An enqueue pulls one block's worth of words from the on-chip side and appends them to the chosen queue. A dequeue removes the first block of a queue and streams its words to the egress side. A bypass moves one block's worth of on-chip words straight to egress without touching memory. One spare block is always held ready, so an enqueue can start writing at once. A block freed by a dequeue goes directly to the next enqueue when no spare is held; otherwise it is pushed onto the free chain.

Top module: `llq_top`

## Requirements
- R1: While reset is held, `outValid`, `memWr`, `errEmpty` and `errNoBlock` are low; a few cycles after release `cmdReady` rises, and from that reset state the free chain hands out blocks in ascending order starting at block 0 (block number all-ones is reserved as the null link, so 2**ADDR_W-1 blocks exist).
- R2: An enqueue (cmdOp 0) asserts `inTake` for `BLK_WORDS` cycles and writes those words to word indices 0..BLK_WORDS-1 of the allocated block, writes the null value into that block's link word (word index BLK_WORDS), and, if the queue already held a block, then writes the new block number into the link word of the old tail block.
- R3: A dequeue (cmdOp 1) of a non-empty queue presents the `BLK_WORDS` words of its first block on `outWord` with `outValid`, in word order, with `outLast` only on the final word; the queue head then advances to the block named by the link word.
- R4: Each queue returns its blocks in the order they were enqueued, independent of traffic on other queues.
- R5: A bypass (cmdOp 2) presents `BLK_WORDS` consecutive `inWord` values on `outWord` in the same cycle as `inTake`, with `outLast` on the final one, and makes no memory access.
- R6: A dequeue of an empty queue is refused: `errEmpty` pulses for one cycle in the cycle after acceptance, and no output word or memory access follows.
- R7: An enqueue while no block is held ready is refused: `errNoBlock` pulses for one cycle in the cycle after acceptance, and no memory write follows.
- R8: An accepted enqueue writes its first data word in the cycle right after acceptance, without waiting on a free-chain read.
- R9: A block freed by a dequeue while no spare is held becomes the spare with no memory write and is the block used by the next enqueue.
- R10: A block freed while a spare is held is pushed at the front of the free chain by writing the previous chain front into its link word; later allocations take it before older free blocks.
- R11: The memory port makes at most one access per cycle; the address is {block number, word index}, and read data is expected on `memRdata` the cycle after `memRd`.
- R12: Commands are accepted only when `cmdReady` and `cmdValid` are both high; cmdOp 3 is accepted and does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | 0 enqueue, 1 dequeue, 2 bypass, 3 no operation |
| cmdQueue | input | $clog2(NUM_Q) | Queue number |
| cmdReady | output | 1 | Block idle, command can be taken |
| inWord | input | DATA_W | Word from the on-chip side |
| inTake | output | 1 | Current `inWord` is consumed this cycle |
| outValid | output | 1 | `outWord` holds an egress word |
| outWord | output | DATA_W | Egress word |
| outLast | output | 1 | Final word of the block |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | ADDR_W+$clog2(BLK_WORDS+1) | {block, word index} |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, one cycle after `memRd` |
| errEmpty | output | 1 | Dequeue refused, queue empty |
| errNoBlock | output | 1 | Enqueue refused, no spare block |

## Verification
The error-pulse properties assume that `cmdOp` is only meaningful with `cmdValid` and that a command is held for exactly the cycle in which it is accepted; the stimulus raises `cmdValid` for one cycle, only while `cmdReady` is high, and drops it afterwards. The egress and bypass properties assume that `inWord` always has a word available while `inTake` is high, which the stimulus supplies by advancing the word on every consumed cycle. The memory model answers every read with exactly one cycle of latency and never stalls, which is what the dequeue timing relies on.

// File: rtl/llq_pkg.sv
package llq_pkg;
  typedef enum logic [1:0] {OP_ENQ = 2'd0, OP_DEQ = 2'd1, OP_BYP = 2'd2, OP_NOP = 2'd3} op_e;
  typedef enum logic [1:0] {A_CUR, A_TAIL, A_FREE} asel_e;
  typedef enum logic [1:0] {W_IN, W_NULL, W_CUR, W_FREE} wsel_e;
  typedef enum logic [3:0] {
    S_IDLE, S_ENQ, S_ENQL, S_POP1, S_POP2, S_DEQ, S_DEQL, S_PUSH, S_BYP
  } state_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic  latchEnq;
    logic  latchDeq;
    asel_e aSel;
    wsel_e wSel;
    logic  enqLink;
    logic  deqLink;
    logic  popList;
    logic  popFresh;
    logic  pushFree;
    logic  recycle;
  } strobe_t;
endpackage

// File: rtl/llq_path.sv
module llq_path import llq_pkg::*; #(
  parameter int NUM_Q  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WIDX_W = 3,
  localparam int QW    = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [QW-1:0]     cmdQueue,
  input  logic [DATA_W-1:0] inWord,
  input  logic [ADDR_W-1:0] linkIn,
  output logic [ADDR_W+WIDX_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              cmdEmpty,
  output logic              curEmpty,
  output logic              preValid,
  output logic              freeNull,
  output logic              freshLeft
);
  localparam logic [ADDR_W-1:0] NULLB = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] headQ [NUM_Q];
  logic [ADDR_W-1:0] tailQ [NUM_Q];
  logic [ADDR_W-1:0] freeHead, freshCnt, preBlk, curBlk, addrBlk;
  logic [QW-1:0]     curQ;

  assign cmdEmpty  = headQ[cmdQueue] == NULLB;
  assign curEmpty  = headQ[curQ] == NULLB;
  assign freeNull  = freeHead == NULLB;
  assign freshLeft = freshCnt != NULLB;

  always_comb begin
    case (st.aSel)
      A_TAIL:  addrBlk = tailQ[curQ];
      A_FREE:  addrBlk = freeHead;
      default: addrBlk = curBlk;
    endcase
    case (st.wSel)
      W_NULL:  memWdata = DATA_W'(NULLB);
      W_CUR:   memWdata = DATA_W'(curBlk);
      W_FREE:  memWdata = DATA_W'(freeHead);
      default: memWdata = inWord;
    endcase
  end
  assign memAddr = {addrBlk, wordIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_Q; i++) begin
        headQ[i] <= NULLB;
        tailQ[i] <= NULLB;
      end
      freeHead <= NULLB;
      freshCnt <= '0;
      preBlk   <= '0;
      preValid <= 1'b0;
      curBlk   <= '0;
      curQ     <= '0;
    end else begin
      if (st.latchEnq) begin
        curQ   <= cmdQueue;
        curBlk <= preBlk;
      end
      if (st.latchDeq) begin
        curQ   <= cmdQueue;
        curBlk <= headQ[cmdQueue];
      end
      if (st.enqLink) begin
        if (curEmpty) headQ[curQ] <= curBlk;
        tailQ[curQ] <= curBlk;
        preValid    <= 1'b0;
      end
      if (st.deqLink) headQ[curQ] <= linkIn;
      if (st.popList) begin
        preBlk   <= freeHead;
        preValid <= 1'b1;
        freeHead <= linkIn;
      end
      if (st.popFresh) begin
        preBlk   <= freshCnt;
        preValid <= 1'b1;
        freshCnt <= freshCnt + 1'b1;
      end
      if (st.pushFree) freeHead <= curBlk;
      if (st.recycle) begin
        preBlk   <= curBlk;
        preValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/llq_ctrl.sv
module llq_ctrl import llq_pkg::*; #(
  parameter int BLK_WORDS = 4,
  parameter int WIDX_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              cmdEmpty,
  input  logic              curEmpty,
  input  logic              preValid,
  input  logic              freeNull,
  input  logic              freshLeft,
  output strobe_t           st,
  output logic              memRd,
  output logic              memWr,
  output logic [WIDX_W-1:0] wordIdx,
  output logic              cmdReady,
  output logic              inTake,
  output logic              outValid,
  output logic              outLast,
  output logic              outFromIn,
  output logic              errEmpty,
  output logic              errNoBlock
);
  localparam logic [WIDX_W-1:0] LINK  = WIDX_W'(BLK_WORDS);
  localparam logic [WIDX_W-1:0] LASTD = WIDX_W'(BLK_WORDS - 1);

  state_e            state, nextState;
  logic [WIDX_W-1:0] cnt, pendIdx;
  logic              pendRd, accept;

  assign cmdReady  = state == S_IDLE;
  assign accept    = cmdValid && cmdReady;
  assign outFromIn = state == S_BYP;
  assign outValid  = outFromIn || pendRd;
  assign outLast   = outFromIn ? (cnt == LASTD) : (pendRd && pendIdx == LASTD);

  always_comb begin
    st        = '0;
    memRd     = 1'b0;
    memWr     = 1'b0;
    inTake    = 1'b0;
    wordIdx   = cnt;
    nextState = state;
    case (state)
      S_IDLE: if (accept) begin
        if (cmdOp == OP_ENQ && preValid) begin
          st.latchEnq = 1'b1;
          nextState   = S_ENQ;
        end else if (cmdOp == OP_DEQ && !cmdEmpty) begin
          st.latchDeq = 1'b1;
          nextState   = S_DEQ;
        end else if (cmdOp == OP_BYP) begin
          nextState = S_BYP;
        end
      end
      S_ENQ: begin
        memWr   = 1'b1;
        st.aSel = A_CUR;
        if (cnt == LINK) begin
          st.wSel   = W_NULL;
          nextState = S_ENQL;
        end else begin
          st.wSel = W_IN;
          inTake  = 1'b1;
        end
      end
      S_ENQL: begin
        memWr      = !curEmpty;
        st.aSel    = A_TAIL;
        st.wSel    = W_CUR;
        wordIdx    = LINK;
        st.enqLink = 1'b1;
        nextState  = S_POP1;
      end
      S_POP1: begin
        if (!freeNull) begin
          memRd     = 1'b1;
          st.aSel   = A_FREE;
          wordIdx   = LINK;
          nextState = S_POP2;
        end else begin
          st.popFresh = freshLeft;
          nextState   = S_IDLE;
        end
      end
      S_POP2: begin
        st.popList = 1'b1;
        nextState  = S_IDLE;
      end
      S_DEQ: begin
        memRd   = 1'b1;
        st.aSel = A_CUR;
        if (cnt == LINK) nextState = S_DEQL;
      end
      S_DEQL: begin
        st.deqLink = 1'b1;
        if (preValid) nextState = S_PUSH;
        else begin
          st.recycle = 1'b1;
          nextState  = S_IDLE;
        end
      end
      S_PUSH: begin
        memWr       = 1'b1;
        st.aSel     = A_CUR;
        st.wSel     = W_FREE;
        wordIdx     = LINK;
        st.pushFree = 1'b1;
        nextState   = S_IDLE;
      end
      S_BYP: begin
        inTake = 1'b1;
        if (cnt == LASTD) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_POP1;
      cnt        <= '0;
      pendRd     <= 1'b0;
      pendIdx    <= '0;
      errEmpty   <= 1'b0;
      errNoBlock <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= '0;
      else if (state == S_ENQ || state == S_DEQ || state == S_BYP) cnt <= cnt + 1'b1;
      pendRd     <= state == S_DEQ && cnt != LINK;
      pendIdx    <= cnt;
      errEmpty   <= accept && cmdOp == OP_DEQ && cmdEmpty;
      errNoBlock <= accept && cmdOp == OP_ENQ && !preValid;
    end
  end
endmodule

// File: rtl/llq_top.sv
module llq_top import llq_pkg::*; #(
  parameter int NUM_Q     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int QW       = $clog2(NUM_Q),
  localparam int WIDX_W   = $clog2(BLK_WORDS + 1),
  localparam int MA_W     = ADDR_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [QW-1:0]     cmdQueue,
  output logic              cmdReady,
  input  logic [DATA_W-1:0] inWord,
  output logic              inTake,
  output logic              outValid,
  output logic [DATA_W-1:0] outWord,
  output logic              outLast,
  output logic              memRd,
  output logic              memWr,
  output logic [MA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              errEmpty,
  output logic              errNoBlock
);
  strobe_t           st;
  logic [WIDX_W-1:0] wordIdx;
  logic              cmdEmpty, curEmpty, preValid, freeNull, freshLeft, outFromIn;

  assign outWord = outFromIn ? inWord : memRdata;

  llq_ctrl #(.BLK_WORDS(BLK_WORDS), .WIDX_W(WIDX_W)) i_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdEmpty, .curEmpty, .preValid, .freeNull,
    .freshLeft, .st, .memRd, .memWr, .wordIdx, .cmdReady, .inTake, .outValid,
    .outLast, .outFromIn, .errEmpty, .errNoBlock
  );

  llq_path #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDX_W(WIDX_W)) i_path (
    .clk, .rstN, .st, .wordIdx, .cmdQueue, .inWord,
    .linkIn(memRdata[ADDR_W-1:0]), .memAddr, .memWdata, .cmdEmpty, .curEmpty,
    .preValid, .freeNull, .freshLeft
  );
endmodule

// File: rtl/llq_chk.sv
module llq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       cmdReady,
  input logic       inTake,
  input logic       outValid,
  input logic       outLast,
  input logic       memRd,
  input logic       memWr,
  input logic       errEmpty,
  input logic       errNoBlock
);
  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));
  // R3
  last_in_word_chk: assert property (@(posedge clk) disable iff (!rstN) outLast |-> outValid);
  // R6
  empty_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errEmpty |-> $past(cmdValid && cmdReady && cmdOp == 2'd1));
  // R6
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errEmpty |-> cmdReady && !outValid && !memWr && !memRd);
  // R7
  noblock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errNoBlock |-> $past(cmdValid && cmdReady && cmdOp == 2'd0));
  // R7
  noblock_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errNoBlock |-> cmdReady && !memWr);
  // R5
  bypass_nomem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inTake && outValid) |-> !memRd && !memWr);
  // R8
  prealloc_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdValid && cmdReady && cmdOp == 2'd0) && !errNoBlock) |-> memWr && inTake);
  // R12
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !inTake && !outValid);
endmodule

bind llq_top llq_chk i_llq_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReady(cmdReady),
  .inTake(inTake), .outValid(outValid), .outLast(outLast), .memRd(memRd),
  .memWr(memWr), .errEmpty(errEmpty), .errNoBlock(errNoBlock)
);

// File: tb/test_llq_top.sv
module test_llq_top;
  localparam int NQ = 8, AW = 8, DW = 32, BW = 4;
  localparam int WIDX = $clog2(BW + 1);
  localparam int MAW = AW + WIDX;
  localparam int LINK = BW;
  localparam int NBLK = (1 << AW) - 1;

  // stimulus / expectation table
  localparam int NV = 18;
  localparam int VOP  [NV] = '{1, 0, 0, 0, 1, 2, 1, 1, 1, 0, 1, 0, 0, 0, 3, 1, 1, 1};
  localparam int VQ   [NV] = '{0, 0, 0, 3, 0, 5, 3, 0, 0, 7, 7, 4, 4, 6, 2, 4, 4, 6};
  localparam int VBASE[NV] = '{0, 'h100, 'h200, 'h300, 'h100, 'h500, 'h300, 'h200, 0,
                               'h700, 'h700, 'h410, 'h420, 'h600, 0, 'h410, 'h420, 'h600};
  localparam int VERR [NV] = '{1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int VBLK [NV] = '{0, 0, 1, 2, 0, 0, 2, 1, 0, 3, 3, 1, 3, 2, 0, 1, 3, 2};
  localparam int VLINK[NV] = '{0, 0, 0, 0, 'hFF, 0, 0, 2, 0, 0, 2, 0, 0, 0, 0, 'hFF, 1, 3};

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [2:0] cmdQueue = '0;
  logic [DW-1:0] inWord = '0, memRdata, outWord, memWdata;
  logic cmdReady, inTake, outValid, outLast, memRd, memWr, errEmpty, errNoBlock;
  logic [MAW-1:0] memAddr;
  logic [DW-1:0] mem [1 << MAW];

  int total = 0, bad = 0, cycles = 0;
  int qCnt [NQ];
  int qTail [NQ];

  always #10 clk = ~clk;

  llq_top i_llq_top (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdQueue, .cmdReady, .inWord, .inTake,
    .outValid, .outWord, .outLast, .memRd, .memWr, .memAddr, .memWdata,
    .memRdata, .errEmpty, .errNoBlock
  );

  always @(posedge clk) begin
    if (memWr) mem[memAddr] <= memWdata;
    if (memRd) memRdata <= mem[memAddr];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int gE, gN, nOut, badOut, nWr, nRd, firstBlk, firstCyc, lastAddr, lastData;

  task automatic runCmd(input int op, input int q, input int base);
    int n = 0, cyc = 0;
    gE = 0; gN = 0; nOut = 0; badOut = 0; nWr = 0; nRd = 0;
    firstBlk = -1; firstCyc = -1; lastAddr = -1; lastData = -1;
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdQueue = 3'(q); inWord = DW'(base);
    @(negedge clk);
    cmdValid = 1'b0;
    forever begin
      cyc++;
      inWord = DW'(base + n);
      #1;
      if (errEmpty) gE = 1;
      if (errNoBlock) gN = 1;
      if (outValid) begin
        if (outWord !== DW'(base + nOut) || outLast !== (nOut == BW - 1)) badOut++;
        nOut++;
      end
      if (memWr) begin
        if (nWr == 0) begin firstBlk = int'(memAddr >> WIDX); firstCyc = cyc; end
        nWr++; lastAddr = int'(memAddr); lastData = int'(memWdata);
      end
      if (memRd) nRd++;
      if (inTake) n++;
      if (cmdReady || cyc > 1000) break;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cmdValid = 1'b0;
    for (int i = 0; i < NQ; i++) begin qCnt[i] = 0; qTail[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    check(!outValid && !memWr && !errEmpty && !errNoBlock, "R1 reset quiet",
          {outValid, memWr, errEmpty, errNoBlock}, 0);
    rstN = 1'b1;
    begin
      int w = 0;
      while (!cmdReady && w < 10) begin @(negedge clk); w++; end
      check(cmdReady === 1'b1, "R1 ready after reset", w, 3);
    end
  endtask

  initial begin
    int okSeq;
    @(negedge clk);
    doReset();

    for (int i = 0; i < NV; i++) begin
      runCmd(VOP[i], VQ[i], VBASE[i]);
      case (VOP[i])
        0: begin
          check(gN == 0, "R7 enqueue accepted", gN, 0);
          check(firstBlk == VBLK[i], i == 1 ? "R1 first block" : "R10 block order", firstBlk, VBLK[i]);
          check(firstCyc == 1, "R8 immediate write", firstCyc, 1);
          check(nWr == BW + 1 + (qCnt[VQ[i]] > 0), "R2 write count", nWr, BW + 1 + (qCnt[VQ[i]] > 0));
          if (qCnt[VQ[i]] > 0)
            check(lastAddr == (qTail[VQ[i]] << WIDX | LINK) && lastData == VBLK[i],
                  "R2 tail link", lastData, VBLK[i]);
          qCnt[VQ[i]]++; qTail[VQ[i]] = VBLK[i];
        end
        1: if (VERR[i] != 0) begin
          check(gE == 1 && nOut == 0 && nWr == 0 && nRd == 0, "R6 empty refused", gE, 1);
        end else begin
          check(nOut == BW && badOut == 0, "R3 R4 dequeue data", badOut, 0);
          check(nWr == 1 && lastAddr == (VBLK[i] << WIDX | LINK) && lastData == VLINK[i],
                "R10 free push", lastData, VLINK[i]);
          qCnt[VQ[i]]--;
        end
        2: check(nOut == BW && badOut == 0 && nWr == 0 && nRd == 0, "R5 bypass", badOut + nWr + nRd, 0);
        default: check(nOut == 0 && nWr == 0 && nRd == 0 && gE == 0 && gN == 0,
                       "R12 no-op ignored", nOut + nWr + nRd, 0);
      endcase
    end

    // exhaustion and direct recycling
    doReset();
    okSeq = 0;
    for (int i = 0; i < NBLK; i++) begin
      runCmd(0, 1, i * 16);
      if (firstBlk != i || gN != 0) okSeq++;
    end
    check(okSeq == 0, "R1 ascending allocation", okSeq, 0);
    runCmd(0, 1, 'h8000);
    check(gN == 1 && nWr == 0, "R7 no block refused", nWr, 0);
    runCmd(1, 1, 0);
    check(nOut == BW && badOut == 0, "R3 dequeue after exhaustion", badOut, 0);
    check(nWr == 0, "R9 recycle without write", nWr, 0);
    runCmd(0, 2, 'h9000);
    check(gN == 0 && firstBlk == 0, "R9 recycled block reused", firstBlk, 0);
    runCmd(0, 2, 'h9100);
    check(gN == 1, "R7 refused again", gN, 1);
    runCmd(1, 1, 16);
    check(nOut == BW && badOut == 0, "R4 second block order", badOut, 0);
    runCmd(1, 2, 'h9000);
    check(nOut == BW && badOut == 0, "R4 other queue intact", badOut, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule